// File: doc/BRIEF.md
# Divider Configuration Port for a Clock Synthesizer

This block keeps the configuration word of a frequency synthesizer. The word has three fields: a 9-bit feedback divide value, a 3-bit output divide code and a 2-bit test-select code. The word can be written over a parallel path or a serial path. On the parallel path, pins set the divider fields while an active-low strobe is low, and the value is frozen when the strobe rises. On the serial path, bits are clocked into a 14-bit shift register. A separate strobe then commits the register contents to the fields. While that strobe is held high, the fields follow every shift.

The block also drives a test pin. In serial mode the test-select code picks one of four sources for it: constant low, the bit leaving the shift register, the feedback divider pulse, or a copy of the output clock. In parallel mode the pin is held low.

All pins are sampled in one system clock domain. Edges of the strobes and of the serial clock are found by comparing each sample with the previous one. A power-on reset clears the test-select code. Until the first load event of either kind, the divider fields follow the parallel pins.

Top module: `synth_cfg_port`

## Requirements
- R1: While `par_load_n` is low, `cfg_m`/`cfg_n` equal the `par_m`/`par_n` pins sampled at the previous clock edge.
- R2: After `par_load_n` is sampled rising, `cfg_m`/`cfg_n` keep the last value taken while it was low. They change only through a serial commit or through a new low phase of `par_load_n`.
- R3: With `par_load_n` high, each sampled rising edge of `ser_clk` shifts `ser_din` into bit 0 of a 14-bit register. The first bit sent lands in bit 13. Field positions are {T1,T0} = bits 13:12, N = bits 11:9, M = bits 8:0, so the frame order is T1, T0, N2..N0, M8..M0.
- R4: A sampled rising edge of `ser_load` (with `par_load_n` high) copies the shift register into `cfg_t`, `cfg_n` and `cfg_m` one clock later.
- R5: While `ser_load` is high, every `ser_clk` rising edge updates the fields with the newly shifted register contents.
- R6: While `ser_load` is low, and after it falls, shifting does not change `cfg_t`, `cfg_n` or `cfg_m`.
- R7: While `par_load_n` is low, `ser_clk` edges neither shift nor commit, and the shift register keeps its contents.
- R8: `test_out` is 0 whenever `par_load_n` is low, whatever `cfg_t` holds.
- R9: With `par_load_n` high, `cfg_t` selects `test_out`: 0 gives 0, 1 gives `ser_dout`, 2 gives `fb_pulse`, 3 gives `out_clk`.
- R10: `ser_dout` is bit 13 of the shift register, so a bit shifted in appears on it after 14 shifts.
- R11: After reset `cfg_t` is 0 and the shift register is 0. Until the first parallel strobe rise or serial commit, `cfg_m`/`cfg_n` follow the parallel pins even with `par_load_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| par_load_n | input | 1 | Parallel strobe: low = transparent, rise = latch; high enables serial mode |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 3 | Parallel output divide code |
| ser_clk | input | 1 | Serial shift clock (edge-sampled) |
| ser_din | input | 1 | Serial data in |
| ser_load | input | 1 | Serial commit strobe |
| fb_pulse | input | 1 | Feedback divider pulse for observation |
| out_clk | input | 1 | Output clock for observation |
| cfg_m | output | 9 | Active feedback divide value |
| cfg_n | output | 3 | Active output divide code |
| cfg_t | output | 2 | Active test-select code |
| ser_dout | output | 1 | Last stage of the shift register |
| test_out | output | 1 | Selected test source |

## Verification
The bench focuses on the strobe edges. It checks that a rising parallel strobe freezes the value taken on the previous clock and not the current pins. A design that latched one cycle late would show the new pin value. It checks that a serial commit uses the register after the shift done in the same cycle while `ser_load` is held high. An off-by-one there would drop the newest bit. It toggles the serial clock during parallel mode: a design that still shifted would corrupt the frame that is committed afterwards. It also checks the power-up tracking window and the forced-low test pin with code 3 loaded. A design without the window would hold zeros, and a mux that ignored the mode would pass `out_clk` through.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  typedef enum logic [1:0] {
    TS_LOW  = 2'd0,
    TS_SDO  = 2'd1,
    TS_FB   = 2'd2,
    TS_CLK  = 2'd3
  } test_sel_e;

  function automatic logic rise_of(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  function automatic logic commit_of(input logic ser_mode, input logic ld_rise,
                                     input logic ld_level, input logic sck_rise);
    return ser_mode & (ld_rise | (ld_level & sck_rise));
  endfunction
endpackage

// File: rtl/cfg_edge_det.sv
module cfg_edge_det #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= sig;
  end

  for (genvar i = 0; i < W; i++) begin : g_edge
    assign rise[i] = cfg_pkg::rise_of(sig[i], prev_q[i]);
  end
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q_nxt,
  output logic         dout
);
  logic [W-1:0] q;

  assign q_nxt = shift_en ? {q[W-2:0], din} : q;
  assign dout  = q[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  // R3
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (q[0] == $past(din)) && (q[W-1:1] == $past(q[W-2:0])));
  // R7
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(q));
endmodule

// File: rtl/cfg_store.sv
module cfg_store #(
  parameter int M_W = 9,
  parameter int N_W = 3,
  parameter int T_W = 2,
  localparam int FW = M_W + N_W + T_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_mode,
  input  logic           par_rise,
  input  logic           commit,
  input  logic [FW-1:0]  frame,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  output logic [M_W-1:0] cfg_m,
  output logic [N_W-1:0] cfg_n,
  output logic [T_W-1:0] cfg_t
);
  logic trk;
  logic take_pins;

  assign take_pins = par_mode | (trk & ~par_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_m <= '0;
      cfg_n <= '0;
      cfg_t <= '0;
      trk   <= 1'b1;
    end else begin
      if (commit) begin
        cfg_t <= frame[FW-1 -: T_W];
        cfg_n <= frame[M_W +: N_W];
        cfg_m <= frame[M_W-1:0];
      end else if (take_pins) begin
        cfg_m <= par_m;
        cfg_n <= par_n;
      end
      if (commit || par_rise) trk <= 1'b0;
    end
  end

  // R1
  par_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_mode |=> (cfg_m == $past(par_m)) && (cfg_n == $past(par_n)));
  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_mode && !commit && !trk) |=> $stable({cfg_t, cfg_n, cfg_m}));
  // R4
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> ({cfg_t, cfg_n, cfg_m} == $past(frame)));
  // R7
  par_keeps_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_mode |=> $stable(cfg_t));
endmodule

// File: rtl/cfg_test_mux.sv
module cfg_test_mux (
  input  logic       par_mode,
  input  logic [1:0] sel,
  input  logic       sdo,
  input  logic       fb,
  input  logic       oclk,
  output logic       tout
);
  import cfg_pkg::*;

  always_comb begin
    tout = 1'b0;
    if (!par_mode) begin
      case (test_sel_e'(sel))
        TS_LOW: tout = 1'b0;
        TS_SDO: tout = sdo;
        TS_FB:  tout = fb;
        TS_CLK: tout = oclk;
        default: tout = 1'b0;
      endcase
    end
  end

  // R8
  always_comb begin
    par_low_chk: assert (!(par_mode && tout));
  end
  // R9
  always_comb begin
    sel_sdo_chk: assert (par_mode || sel != 2'd1 || tout == sdo);
  end
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port #(
  parameter int M_W = 9,
  parameter int N_W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_load_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_clk,
  input  logic           ser_din,
  input  logic           ser_load,
  input  logic           fb_pulse,
  input  logic           out_clk,
  output logic [M_W-1:0] cfg_m,
  output logic [N_W-1:0] cfg_n,
  output logic [1:0]     cfg_t,
  output logic           ser_dout,
  output logic           test_out
);
  localparam int T_W = 2;
  localparam int FW  = M_W + N_W + T_W;
  localparam int IX_SCK = 0;
  localparam int IX_LD  = 1;
  localparam int IX_PAR = 2;

  logic [2:0]    rises;
  logic          sck_rise, ld_rise, par_rise;
  logic          par_mode, shift_en, commit;
  logic [FW-1:0] frame_nxt;

  cfg_edge_det #(.W(3), .RST_VAL(3'b100)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .sig  ({par_load_n, ser_load, ser_clk}),
    .rise (rises)
  );

  assign sck_rise = rises[IX_SCK];
  assign ld_rise  = rises[IX_LD];
  assign par_rise = rises[IX_PAR];
  assign par_mode = ~par_load_n;
  assign shift_en = par_load_n & sck_rise;
  assign commit   = cfg_pkg::commit_of(par_load_n, ld_rise, ser_load, sck_rise);

  cfg_shifter #(.W(FW)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(shift_en),
    .din     (ser_din),
    .q_nxt   (frame_nxt),
    .dout    (ser_dout)
  );

  cfg_store #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .par_mode(par_mode),
    .par_rise(par_rise),
    .commit  (commit),
    .frame   (frame_nxt),
    .par_m   (par_m),
    .par_n   (par_n),
    .cfg_m   (cfg_m),
    .cfg_n   (cfg_n),
    .cfg_t   (cfg_t)
  );

  cfg_test_mux u_mux (
    .par_mode(par_mode),
    .sel     (cfg_t),
    .sdo     (ser_dout),
    .fb      (fb_pulse),
    .oclk    (out_clk),
    .tout    (test_out)
  );

  // R11
  rst_t_clear_chk: assert property (@(posedge clk) !rst_n |-> (cfg_t == 2'd0));
  // R6
  ser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_load_n && !ser_load && !ld_rise && sck_rise) |=> $stable(cfg_t));
endmodule

// File: tb/sim_synth_cfg_port.sv
module sim_synth_cfg_port;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic par_load_n = 1'b1;
  logic [8:0] par_m = 9'd123;
  logic [2:0] par_n = 3'd5;
  logic ser_clk = 1'b0, ser_din = 1'b0, ser_load = 1'b0;
  logic fb_pulse = 1'b0, out_clk = 1'b0;
  logic [8:0] cfg_m;
  logic [2:0] cfg_n;
  logic [1:0] cfg_t;
  logic ser_dout, test_out;

  synth_cfg_port u0 (
    .clk(clk), .rst_n(rst_n), .par_load_n(par_load_n), .par_m(par_m), .par_n(par_n),
    .ser_clk(ser_clk), .ser_din(ser_din), .ser_load(ser_load), .fb_pulse(fb_pulse),
    .out_clk(out_clk), .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t),
    .ser_dout(ser_dout), .test_out(test_out)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mm = 0, mn = 0, mt = 0;
  bit trk = 1, plo_p = 1, sl_p = 0, sc_p = 0;
  bit sq[$];

  always @(posedge clk) begin : model
    bit sr, lr, pr;
    if (!rst_n) begin
      mm = 0; mn = 0; mt = 0; trk = 1; plo_p = 1; sl_p = 0; sc_p = 0;
      sq = {};
      for (int i = 0; i < 14; i++) sq.push_back(1'b0);
    end else begin
      sr = ser_clk && !sc_p;
      lr = ser_load && !sl_p;
      pr = par_load_n && !plo_p;
      if (par_load_n && sr) begin
        sq.push_back(ser_din);
        void'(sq.pop_front());
      end
      if (par_load_n && (lr || (ser_load && sr))) begin
        mt = sq[0] * 2 + sq[1];
        mn = sq[2] * 4 + sq[3] * 2 + sq[4];
        mm = 0;
        for (int i = 5; i < 14; i++) mm = mm * 2 + sq[i];
        trk = 0;
      end else if (!par_load_n || (trk && !pr)) begin
        mm = par_m; mn = par_n;
      end
      if (pr) trk = 0;
      plo_p = par_load_n; sl_p = ser_load; sc_p = ser_clk;
    end
  end

  always @(negedge clk) begin : compare
    int et;
    #3;
    if (sq.size() == 14) begin
      chk("R1/R2/R4/R5 model cfg_m", cfg_m, mm);
      chk("R1/R2/R4/R5 model cfg_n", cfg_n, mn);
      chk("R4/R11 model cfg_t", cfg_t, mt);
      chk("R10 model ser_dout", ser_dout, sq[0]);
      if (!par_load_n) et = 0;
      else case (mt)
        1: et = sq[0];
        2: et = fb_pulse;
        3: et = out_clk;
        default: et = 0;
      endcase
      chk("R8/R9 model test_out", test_out, et);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic send_bit(input logic b);
    tick(); ser_din = b; ser_clk = 1'b1;
    tick(); ser_clk = 1'b0;
  endtask

  task automatic send_frame(input logic [13:0] f);
    for (int i = 13; i >= 0; i--) send_bit(f[i]);
  endtask

  task automatic commit_pulse();
    tick(); ser_load = 1'b1;
    tick(); ser_load = 1'b0;
    tick();
  endtask

  initial begin : stim
    logic [13:0] f;
    logic [13:0] f2;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R11: reset state and power-up tracking with par_load_n high
    chk("R11 cfg_t after reset", cfg_t, 0);
    chk("R11 ser_dout after reset", ser_dout, 0);
    chk("R11 tracks par_m", cfg_m, 123);
    par_m = 9'd200; par_n = 3'd2;
    tick();
    chk("R11 tracks new par_m", cfg_m, 200);
    chk("R11 tracks new par_n", cfg_n, 2);

    // R1: transparent parallel phase
    par_load_n = 1'b0; par_m = 9'd300; par_n = 3'd6;
    tick();
    chk("R1 follow m", cfg_m, 300);
    par_m = 9'd111; par_n = 3'd1;
    tick();
    chk("R1 follow m again", cfg_m, 111);
    chk("R1 follow n again", cfg_n, 1);
    // R2: rise latches previous value
    par_load_n = 1'b1; par_m = 9'd7; par_n = 3'd7;
    tick();
    chk("R2 latched m", cfg_m, 111);
    tick();
    par_m = 9'd456;
    tick();
    chk("R2 hold m", cfg_m, 111);
    chk("R2 hold n", cfg_n, 1);

    // R3/R6: shift a frame with load low, no change
    f = {2'b00, 3'd4, 9'd345};
    send_frame(f);
    tick();
    chk("R6 no change while load low", cfg_m, 111);
    chk("R10 ser_dout is first bit", ser_dout, f[13]);
    // R4: commit
    commit_pulse();
    chk("R4 commit m", cfg_m, 345);
    chk("R4 commit n", cfg_n, 4);
    chk("R3 commit t", cfg_t, 0);
    // R6: after fall, shifting holds
    send_bit(1'b1);
    tick();
    chk("R6 hold after fall", cfg_m, 345);
    chk("R10 next bit out", ser_dout, f[12]);

    // R5: load held high, each shift updates
    f2 = {f[12:0], 1'b1};
    tick(); ser_load = 1'b1;
    tick();
    chk("R5 commit at rise", cfg_m, f2[8:0]);
    for (int k = 0; k < 3; k++) begin
      send_bit(k[0]);
      f2 = {f2[12:0], k[0]};
      tick();
      chk("R5 pass-through m", cfg_m, f2[8:0]);
      chk("R5 pass-through n", cfg_n, f2[11:9]);
    end
    ser_load = 1'b0;
    tick();

    // R9: each test-select code
    for (int c = 0; c < 4; c++) begin
      f = {c[1:0], 3'd3, 9'd170};
      send_frame(f);
      commit_pulse();
      chk("R9 code loaded", cfg_t, c);
      fb_pulse = 1'b1; out_clk = 1'b0;
      tick();
      chk("R9 test_out a", test_out,
          (c == 1) ? ser_dout : (c == 2) ? 1 : 0);
      fb_pulse = 1'b0; out_clk = 1'b1;
      tick();
      chk("R9 test_out b", test_out,
          (c == 1) ? ser_dout : (c == 3) ? 1 : 0);
    end

    // R8: parallel mode forces low even with code 3
    par_load_n = 1'b0; out_clk = 1'b1;
    tick();
    chk("R8 forced low", test_out, 0);
    chk("R8 t kept", cfg_t, 3);
    // R7: serial clock ignored in parallel mode
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    chk("R7 ser_dout unchanged", ser_dout, 1'b1);
    tick(); ser_load = 1'b1; tick(); ser_load = 1'b0; tick();
    chk("R7 no commit in parallel", cfg_t, 3);
    chk("R1 still follows", cfg_m, 456);
    par_load_n = 1'b1;
    tick();
    commit_pulse();
    chk("R7 frame intact m", cfg_m, 170);
    chk("R7 frame intact t", cfg_t, 3);

    repeat (4) tick();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule